// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Unit

This unit sits beside a BCD calendar counter and decides when a programmed alarm has come due. Three alarm registers hold a minute, an hour and a third field. The third field is either a seven-bit weekday mask or a BCD day of month, chosen by a control bit. Each register carries a disable bit in its top position. The calendar logic issues a compare strobe after each carry and tags it with how far the carry reached (minute, hour or day). The unit compares only when that carry reaches the lowest field still enabled, so an alarm fires once per real crossing and never because software loaded the time.

A match sets a sticky alarm flag. Two supply-event inputs set their own sticky flags, and a fourth flag records oscillator supply loss. Software clears a flag by writing 0 to its bit; writing 1 leaves it as it is. The unit ORs the enabled flags and drives the result through one register to an output-enable that pulls the open-drain interrupt line low.

Top module: `alm_irq_unit`

## Requirements
- R1: Bit 7 of each alarm register (address 0 minute, 1 hour, 2 weekday/date) disables its field when 1. When it is 0, bits 6:0 must equal calendar bits 6:0 for that field to match. When every field is disabled, any strobe counts as a match.
- R2: Control bit 0 (address 3) selects the third field. At 0, a match needs some set bit of alarm bits 6:0 to coincide with the one-hot weekday input. At 1, alarm bits 6:0 must equal day-of-month bits 6:0.
- R3: Flag register (address 4) bit 0 is the alarm flag. A match sets it, and it stays set until a write with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged. The flags are read back on `flags`, one cycle after the edge that sets or clears them.
- R4: `irq_oe` is 1 in the cycle after an edge where (flag0 and control bit 1) or (flag1 and control bit 2) or (flag2 and control bit 3) held; otherwise it is 0 (line released).
- R5: A match needs `cmp_stb` = 1 and `cmp_lvl` (0 minute, 1 hour, 2 day) at least the level of the lowest enabled field. A calendar equal to the alarm without such a strobe sets nothing.
- R6: A write to addresses 0..2 in the strobe cycle suppresses that comparison. A write that clears flag bit 0 in the match cycle wins, and the flag ends at 0.
- R7: `ext_low` sets flag bit 1 and `bak_low` sets flag bit 2. Both are sticky until written 0. An event in the same cycle as a clear leaves the bit set.
- R8: `osc_loss` sets flag bit 3, which is cleared the same way but never drives `irq_oe`.
- R9: Synchronous reset clears all registers, all flags and `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cal_min | input | 8 | Calendar minute, BCD |
| cal_hour | input | 8 | Calendar hour, BCD |
| cal_wday | input | 7 | Calendar weekday, one-hot |
| cal_mday | input | 8 | Calendar day of month, BCD |
| cmp_stb | input | 1 | Compare strobe after a carry |
| cmp_lvl | input | 2 | Carry reach: 0 minute, 1 hour, 2 day |
| ext_low | input | 1 | External supply low event |
| bak_low | input | 1 | Backup supply low event |
| osc_loss | input | 1 | Oscillator supply loss event |
| flags | output | 4 | Flag readback {osc, backup, external, alarm} |
| irq_oe | output | 1 | 1 pulls the interrupt line low |

## Verification
A wrong alarm register or a wrong field decode appears on `flags` bit 0 one cycle after the strobe that should or should not have matched. A bad enable combination or a stuck flag appears on `irq_oe` one cycle after that. Sticky flags keep any wrong set or missed clear visible until the next deliberate clear, so the per-cycle comparison against the bench's own model catches it at once. Directed cases cover the single-cycle collisions (strobe against alarm write, match against clear, event against clear), because random traffic reaches them only rarely.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WDAY_W = 7;
  localparam int unsigned NALM   = 3;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned NCTRL  = 4;

  localparam int unsigned ADR_CTRL = 3;
  localparam int unsigned ADR_FLAG = 4;

  localparam int unsigned F_ALM = 0;
  localparam int unsigned F_EXT = 1;
  localparam int unsigned F_BAK = 2;
  localparam int unsigned F_OSC = 3;

  localparam logic [1:0] LV_MIN  = 2'd0;
  localparam logic [1:0] LV_HOUR = 2'd1;
  localparam logic [1:0] LV_DAY  = 2'd2;

  typedef struct packed {
    logic bie;
    logic eie;
    logic aie;
    logic dsel;
  } ctrl_t;
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] alm_min,
  output logic [DW-1:0] alm_hour,
  output logic [DW-1:0] alm_day,
  output ctrl_t         ctrl,
  output logic          alm_wr_busy
);
  logic [DW-1:0] alm_q [NALM];
  ctrl_t         ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NALM); i++) alm_q[i] <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < int'(NALM); i++)
        if (wr_addr == AW'(i)) alm_q[i] <= wr_data;
      if (wr_addr == AW'(ADR_CTRL)) ctrl_q <= ctrl_t'(wr_data[NCTRL-1:0]);
    end
  end

  assign alm_min     = alm_q[0];
  assign alm_hour    = alm_q[1];
  assign alm_day     = alm_q[2];
  assign ctrl        = ctrl_q;
  assign alm_wr_busy = wr_en && (wr_addr < AW'(NALM));
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WDAY_W
) (
  input  logic [DW-1:0] alm_min,
  input  logic [DW-1:0] alm_hour,
  input  logic [DW-1:0] alm_day,
  input  logic          dsel,
  input  logic [DW-1:0] cal_min,
  input  logic [DW-1:0] cal_hour,
  input  logic [WW-1:0] cal_wday,
  input  logic [DW-1:0] cal_mday,
  input  logic          cmp_stb,
  input  logic [1:0]    cmp_lvl,
  input  logic          inhibit,
  output logic          hit
);
  localparam int unsigned FW = DW - 1;

  logic min_on, hour_on, day_on;
  logic min_eq, hour_eq, day_eq;
  logic lvl_ok;

  assign min_on  = ~alm_min[DW-1];
  assign hour_on = ~alm_hour[DW-1];
  assign day_on  = ~alm_day[DW-1];

  assign min_eq  = alm_min[FW-1:0]  == cal_min[FW-1:0];
  assign hour_eq = alm_hour[FW-1:0] == cal_hour[FW-1:0];
  assign day_eq  = dsel ? (alm_day[FW-1:0] == cal_mday[FW-1:0])
                        : |(alm_day[WW-1:0] & cal_wday);

  always_comb begin
    if (min_on)       lvl_ok = 1'b1;
    else if (hour_on) lvl_ok = cmp_lvl >= LV_HOUR;
    else if (day_on)  lvl_ok = cmp_lvl >= LV_DAY;
    else              lvl_ok = 1'b1;
  end

  assign hit = cmp_stb && !inhibit && lvl_ok &&
               (!min_on || min_eq) && (!hour_on || hour_eq) && (!day_on || day_eq);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import alm_pkg::*;
#(
  parameter int unsigned NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          fwr,
  input  logic [NF-1:0] fwd,
  input  logic          ext_low,
  input  logic          bak_low,
  input  logic          osc_loss,
  input  ctrl_t         ctrl,
  output logic [NF-1:0] flags_q,
  output logic          irq_oe
);
  logic [NF-1:0] ev;
  logic [NF-1:0] clr;
  logic          irq_q;

  assign ev  = NF'({osc_loss, bak_low, ext_low, 1'b0});
  assign clr = fwr ? ~fwd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (clr[F_ALM])  flags_q[F_ALM] <= 1'b0;
      else if (hit)    flags_q[F_ALM] <= 1'b1;
      for (int i = 1; i < int'(NF); i++) begin
        if (ev[i])       flags_q[i] <= 1'b1;
        else if (clr[i]) flags_q[i] <= 1'b0;
      end
      irq_q <= (flags_q[F_ALM] & ctrl.aie) | (flags_q[F_EXT] & ctrl.eie) |
               (flags_q[F_BAK] & ctrl.bie);
    end
  end

  assign irq_oe = irq_q;

  p_alarm_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (flags_q[F_ALM] && !(fwr && !fwd[F_ALM])) |=> flags_q[F_ALM]);
  p_clear_beats_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (fwr && !fwd[F_ALM]) |=> !flags_q[F_ALM]);
  p_supply_set_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_low || bak_low) |=> (flags_q[F_EXT] || flags_q[F_BAK]));
  p_osc_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (!flags_q[F_ALM] && !flags_q[F_EXT] && !flags_q[F_BAK]) |=> !irq_oe);
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.aie && !ctrl.eie && !ctrl.bie) |=> !irq_oe);
endmodule

// File: rtl/alm_irq_unit.sv
module alm_irq_unit
  import alm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned WW = WDAY_W,
  parameter int unsigned NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] cal_min,
  input  logic [DW-1:0] cal_hour,
  input  logic [WW-1:0] cal_wday,
  input  logic [DW-1:0] cal_mday,
  input  logic          cmp_stb,
  input  logic [1:0]    cmp_lvl,
  input  logic          ext_low,
  input  logic          bak_low,
  input  logic          osc_loss,
  output logic [NF-1:0] flags,
  output logic          irq_oe
);
  logic [DW-1:0] alm_min, alm_hour, alm_day;
  ctrl_t         ctrl;
  logic          busy;
  logic          hit_w;
  logic          fwr;

  assign fwr = wr_en && (wr_addr == AW'(ADR_FLAG));

  alm_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
    .ctrl(ctrl), .alm_wr_busy(busy)
  );

  alm_match #(.DW(DW), .WW(WW)) u_match (
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day), .dsel(ctrl.dsel),
    .cal_min(cal_min), .cal_hour(cal_hour), .cal_wday(cal_wday), .cal_mday(cal_mday),
    .cmp_stb(cmp_stb), .cmp_lvl(cmp_lvl), .inhibit(busy), .hit(hit_w)
  );

  irq_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst(rst), .hit(hit_w), .fwr(fwr), .fwd(wr_data[NF-1:0]),
    .ext_low(ext_low), .bak_low(bak_low), .osc_loss(osc_loss), .ctrl(ctrl),
    .flags_q(flags), .irq_oe(irq_oe)
  );

  p_wr_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < AW'(NALM)) |-> !hit_w);
  p_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !cmp_stb |-> !hit_w);
endmodule

// File: tb/alm_irq_unit_tb.sv
module alm_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cal_min = '0, cal_hour = '0, cal_mday = 8'h01;
  logic [6:0] cal_wday = 7'h01;
  logic       cmp_stb = 1'b0;
  logic [1:0] cmp_lvl = '0;
  logic       ext_low = 1'b0, bak_low = 1'b0, osc_loss = 1'b0;
  logic [3:0] flags;
  logic       irq_oe;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  logic [7:0] m_alm [3];
  logic [3:0] m_ctrl;
  logic [3:0] m_flg;
  logic       m_irq;

  alm_irq_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_min(cal_min), .cal_hour(cal_hour), .cal_wday(cal_wday), .cal_mday(cal_mday),
    .cmp_stb(cmp_stb), .cmp_lvl(cmp_lvl), .ext_low(ext_low), .bak_low(bak_low),
    .osc_loss(osc_loss), .flags(flags), .irq_oe(irq_oe)
  );

  always #5 clk = ~clk;

  function automatic logic exp_hit();
    logic on_m, on_h, on_d, ok_m, ok_h, ok_d, lvl;
    on_m = !m_alm[0][7];
    on_h = !m_alm[1][7];
    on_d = !m_alm[2][7];
    ok_m = m_alm[0][6:0] == cal_min[6:0];
    ok_h = m_alm[1][6:0] == cal_hour[6:0];
    ok_d = m_ctrl[0] ? (m_alm[2][6:0] == cal_mday[6:0]) : ((m_alm[2][6:0] & cal_wday) != 0);
    if (on_m)      lvl = 1'b1;
    else if (on_h) lvl = cmp_lvl >= 2'd1;
    else if (on_d) lvl = cmp_lvl >= 2'd2;
    else           lvl = 1'b1;
    if (!cmp_stb || (wr_en && wr_addr < 3'd3)) return 1'b0;
    return lvl && (!on_m || ok_m) && (!on_h || ok_h) && (!on_d || ok_d);
  endfunction

  task automatic model_step();
    logic h;
    logic [3:0] clr;
    if (rst) begin
      for (int i = 0; i < 3; i++) m_alm[i] = '0;
      m_ctrl = '0; m_flg = '0; m_irq = 1'b0;
      return;
    end
    h   = exp_hit();
    clr = (wr_en && wr_addr == 3'd4) ? ~wr_data[3:0] : 4'h0;
    m_irq = (m_flg[0] & m_ctrl[1]) | (m_flg[1] & m_ctrl[2]) | (m_flg[2] & m_ctrl[3]);
    m_flg[0] = clr[0] ? 1'b0 : (m_flg[0] | h);
    m_flg[1] = ext_low  ? 1'b1 : (clr[1] ? 1'b0 : m_flg[1]);
    m_flg[2] = bak_low  ? 1'b1 : (clr[2] ? 1'b0 : m_flg[2]);
    m_flg[3] = osc_loss ? 1'b1 : (clr[3] ? 1'b0 : m_flg[3]);
    if (wr_en && wr_addr < 3'd3) m_alm[wr_addr] = wr_data;
    if (wr_en && wr_addr == 3'd3) m_ctrl = wr_data[3:0];
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    if (!rst) begin
      chk("R3/R7 flags vs model", {4'h0, flags}, {4'h0, m_flg});
      chk("R4 irq vs model", {7'h0, irq_oe}, {7'h0, m_irq});
    end
    wr_en = 1'b0; cmp_stb = 1'b0;
    ext_low = 1'b0; bak_low = 1'b0; osc_loss = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic stb(input logic [1:0] lv);
    cmp_stb = 1'b1; cmp_lvl = lv;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst = 1'b0;
    chk("R9 reset flags", {4'h0, flags}, 8'h00);
    chk("R9 reset irq", {7'h0, irq_oe}, 8'h00);

    // R1: minute enabled, hour and day disabled
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h05); wr(3'd1, 8'h80); wr(3'd2, 8'h80);
    cal_min = 8'h05; cal_hour = 8'h13; cal_wday = 7'h01;
    stb(2'd0);
    chk("R1 minute match sets flag", {4'h0, flags}, 8'h01);
    chk("R4 irq not yet", {7'h0, irq_oe}, 8'h00);
    tick();
    chk("R4 irq pulls low", {7'h0, irq_oe}, 8'h01);
    // R3: write 1 keeps, write 0 clears
    wr(3'd4, 8'h0F);
    chk("R3 write one keeps", {4'h0, flags}, 8'h01);
    wr(3'd4, 8'h0E);
    chk("R3 write zero clears", {4'h0, flags}, 8'h00);
    tick();
    chk("R4 irq released", {7'h0, irq_oe}, 8'h00);
    wr(3'd0, 8'h07);
    stb(2'd0);
    chk("R1 enabled field mismatch", {4'h0, flags}, 8'h00);

    // R5: hour is lowest enabled
    wr(3'd0, 8'h80); wr(3'd1, 8'h13);
    stb(2'd0);
    chk("R5 minute carry ignored", {4'h0, flags}, 8'h00);
    tick();
    chk("R5 no strobe no match", {4'h0, flags}, 8'h00);
    stb(2'd1);
    chk("R5 hour carry matches", {4'h0, flags}, 8'h01);
    wr(3'd4, 8'h00);

    // R2: weekday mask then date
    wr(3'd1, 8'h80); wr(3'd2, 8'h22);
    cal_wday = 7'h04;
    stb(2'd2);
    chk("R2 weekday not in mask", {4'h0, flags}, 8'h00);
    cal_wday = 7'h20;
    stb(2'd2);
    chk("R2 weekday in mask", {4'h0, flags}, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h03); wr(3'd2, 8'h15);
    cal_mday = 8'h15;
    stb(2'd2);
    chk("R2 date match", {4'h0, flags}, 8'h01);
    wr(3'd4, 8'h00);

    // R6: collisions
    cmp_stb = 1'b1; cmp_lvl = 2'd2;
    wr(3'd0, 8'h80);
    chk("R6 alarm write inhibits", {4'h0, flags}, 8'h00);
    cmp_stb = 1'b1; cmp_lvl = 2'd2;
    wr(3'd4, 8'h0E);
    chk("R6 clear beats match", {4'h0, flags}, 8'h00);
    stb(2'd2);
    chk("R6 match after collision", {4'h0, flags}, 8'h01);
    wr(3'd4, 8'h00);

    // R7: supply flags
    wr(3'd3, 8'h00);
    ext_low = 1'b1; tick();
    chk("R7 ext flag set", {4'h0, flags}, 8'h02);
    tick();
    chk("R7 ext flag sticky", {4'h0, flags}, 8'h02);
    chk("R7 masked irq", {7'h0, irq_oe}, 8'h00);
    wr(3'd3, 8'h04); tick();
    chk("R7 ext irq", {7'h0, irq_oe}, 8'h01);
    ext_low = 1'b1;
    wr(3'd4, 8'h0D);
    chk("R7 event beats clear", {4'h0, flags}, 8'h02);
    wr(3'd4, 8'h0D);
    chk("R7 ext cleared", {4'h0, flags}, 8'h00);
    bak_low = 1'b1; tick();
    chk("R7 backup flag set", {4'h0, flags}, 8'h04);
    wr(3'd3, 8'h08); tick();
    chk("R7 backup irq", {7'h0, irq_oe}, 8'h01);
    wr(3'd4, 8'h00);

    // R8: oscillator loss never interrupts
    wr(3'd3, 8'h0E);
    osc_loss = 1'b1; tick();
    chk("R8 osc flag set", {4'h0, flags}, 8'h08);
    tick(); tick();
    chk("R8 osc no irq", {7'h0, irq_oe}, 8'h00);
    wr(3'd4, 8'h00);

    // random traffic checked against the model every cycle (R1..R8)
    for (int n = 0; n < 4000; n++) begin
      cal_min  = 8'($urandom_range(0, 2));
      cal_hour = 8'($urandom_range(0, 1));
      cal_mday = 8'($urandom_range(1, 2));
      cal_wday = 7'(1 << $urandom_range(0, 6));
      if ($urandom_range(0, 7) == 0) begin
        wr_en   = 1'b1;
        wr_addr = 3'($urandom_range(0, 4));
        if (wr_addr < 3'd3)
          wr_data = {($urandom_range(0, 3) == 0), 7'($urandom_range(0, 2))};
        else
          wr_data = 8'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 2) == 0) begin
        cmp_stb = 1'b1; cmp_lvl = 2'($urandom_range(0, 2));
      end
      ext_low  = ($urandom_range(0, 39) == 0);
      bak_low  = ($urandom_range(0, 39) == 0);
      osc_loss = ($urandom_range(0, 59) == 0);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule